// File: doc/BRIEF.md
# PS/2 Keycode Read Port

This block takes scan codes from a keyboard over the two-wire PS/2 link and offers the most recent one on a single read-only 8-bit I/O port of a Z80-style bus. The keyboard clock and data lines are synchronized into the system clock domain. Each frame is shifted in on the falling edge of the keyboard clock and checked. A frame that passes the checks loads its data byte into a one-entry holding stage.

The holding stage feeds an output latch that the CPU reads. The start of a port read zeroes the holding stage at once. The output latch keeps its value for the whole read cycle. It picks up the zero only after the read strobe is released. Because of this, a later read returns zero unless a new key has arrived, and zero means that no key is waiting. A code that arrives during a read is kept and shows on the next read.

Top module: `ps2_key_port`

## Requirements
- R1: After reset the output latch holds 0x00 and the bus driver enable `data_oe_o` is low.
- R2: `data_oe_o` is high exactly while `iorq_ni` is low, `rd_ni` is low and address bit 3 is high. The other address bits have no effect on it.
- R3: When `iorq_ni` is high, or `rd_ni` is high (for example during a write cycle), the port never drives the bus and the held keycode is not cleared.
- R4: A valid frame loads its data byte into the holding stage. A valid frame has a start bit of 0, eight data bits sent LSB first, an odd parity bit and a stop bit of 1, each sampled on a keyboard clock falling edge. The byte is readable on the port within two system clocks of the stop bit being seen.
- R5: The first clock of a port read zeroes the holding stage. The next read returns 0x00 if no frame arrived in between.
- R6: `data_o` stays stable for the whole of a port read, including any cycle in which the holding stage is cleared or reloaded.
- R7: A frame whose parity bit gives even parity over the data byte and parity bit is dropped, and the previous code is kept.
- R8: A frame whose stop bit is 0 is dropped, and the previous code is kept.
- R9: A falling keyboard clock edge that samples data 1 while the receiver is idle does not start a frame.
- R10: A new valid code overwrites a code that has not yet been read.
- R11: If a partial frame sees no keyboard clock falling edge for `TIMEOUT_CYC` system clocks, the receiver returns to idle, and the next frame is received correctly.
- R12: A valid code that completes while a port read is in progress is not lost. It is returned by the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data line (asynchronous) |
| iorq_ni | input | 1 | Active-low I/O request strobe |
| rd_ni | input | 1 | Active-low read strobe |
| addr_i | input | 8 | Low I/O address byte |
| data_o | output | 8 | Keycode value for the data bus |
| data_oe_o | output | 1 | Tri-state driver enable for `data_o` |

## Verification
The receiver is driven with random data bytes in valid frames, in frames with wrong parity or a low stop bit, and in an all-ones burst that has no start bit. These tell a correct frame check apart from one that accepts corrupt frames or shifts in the wrong bit order. The bus side mixes matching reads with cycles that have address bit 3 low, random upper address bits, or the read strobe inactive. This separates a correct decode from one that reads too much or too little of the address. Directed cases cover a read that is held open while a frame completes, a second read that must return zero, two frames sent without a read between them, and a frame that is cut off and then followed by a timeout.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;
  localparam int KC_W       = 8;
  localparam int FRAME_BITS = 11;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  typedef logic [KC_W-1:0] keycode_t;
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '1;  // idle lines are high
      else if (s == 0) chain_q[s] <= async_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_port_pkg::*;
#(
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     kclk_i,
  input  logic     kdat_i,
  output logic     code_vld_o,
  output keycode_t code_o
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  logic             kclk_q;
  logic             fall;
  logic [CNT_W-1:0] bit_q;
  keycode_t         sh_q;
  logic             par_q;
  logic [TO_W-1:0]  to_q;

  assign fall = kclk_q & ~kclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kclk_q     <= 1'b1;
      bit_q      <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      to_q       <= '0;
      code_vld_o <= 1'b0;
      code_o     <= '0;
    end else begin
      kclk_q     <= kclk_i;
      code_vld_o <= 1'b0;
      if (fall) begin
        to_q <= '0;
        if (bit_q == '0) begin
          if (!kdat_i) bit_q <= CNT_W'(1);  // start bit
        end else if (bit_q <= CNT_W'(KC_W)) begin
          sh_q  <= {kdat_i, sh_q[KC_W-1:1]};
          bit_q <= bit_q + CNT_W'(1);
        end else if (bit_q == CNT_W'(KC_W + 1)) begin
          par_q <= kdat_i;
          bit_q <= bit_q + CNT_W'(1);
        end else begin
          bit_q <= '0;
          if (kdat_i && (^{sh_q, par_q})) begin
            code_vld_o <= 1'b1;
            code_o     <= sh_q;
          end
        end
      end else if (bit_q != '0) begin
        if (to_q == TO_W'(TIMEOUT_CYC - 1)) begin
          bit_q <= '0;
          to_q  <= '0;
        end else begin
          to_q <= to_q + TO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/keycode_latch.sv
module keycode_latch
  import ps2_port_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     code_vld_i,
  input  keycode_t code_i,
  input  logic     rd_sel_i,
  output keycode_t stage_o,
  output keycode_t out_o,
  output logic     rd_start_o
);
  logic sel_q;

  assign rd_start_o = rd_sel_i & ~sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      stage_o <= '0;
      out_o   <= '0;
    end else begin
      sel_q <= rd_sel_i;
      // new code wins over the clear so nothing is lost
      if (code_vld_i)      stage_o <= code_i;
      else if (rd_start_o) stage_o <= '0;
      // latch refresh only outside a read
      if (!rd_sel_i) out_o <= stage_o;
    end
  end
endmodule

// File: rtl/ps2_key_port.sv
module ps2_key_port
  import ps2_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 10000,
  parameter int ADDR_W      = 8,
  parameter int SEL_BIT     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [KC_W-1:0]   data_o,
  output logic              data_oe_o
);
  logic [1:0] line_s;
  logic       rd_sel;
  logic       code_vld;
  logic       rd_start;
  keycode_t   code;
  keycode_t   stage;

  assign rd_sel    = ~iorq_ni & ~rd_ni & addr_i[SEL_BIT];
  assign data_oe_o = rd_sel;

  ps2_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ps2_dat_i, ps2_clk_i}),
    .sync_o (line_s)
  );

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kclk_i    (line_s[0]),
    .kdat_i    (line_s[1]),
    .code_vld_o(code_vld),
    .code_o    (code)
  );

  keycode_latch i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_vld_i(code_vld),
    .code_i    (code),
    .rd_sel_i  (rd_sel),
    .stage_o   (stage),
    .out_o     (data_o),
    .rd_start_o(rd_start)
  );
endmodule

// File: rtl/ps2_key_port_chk.sv
module ps2_key_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       iorq_ni,
  input logic       rd_ni,
  input logic [7:0] addr_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       code_vld,
  input logic [7:0] code,
  input logic [7:0] stage,
  input logic       rd_start
);
  // R3
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_ni || rd_ni) |-> !data_oe_o);
  // R2
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> addr_i[3]);
  // R6
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(data_oe_o) |-> $stable(data_o));
  // R5
  clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start && !code_vld) |=> stage == 8'h00);
  // R4
  load_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld |=> stage == $past(code));
endmodule

bind ps2_key_port ps2_key_port_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .iorq_ni  (iorq_ni),
  .rd_ni    (rd_ni),
  .addr_i   (addr_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .code_vld (code_vld),
  .code     (code),
  .stage    (stage),
  .rd_start (rd_start)
);

// File: tb/test_ps2_key_port.sv
module test_ps2_key_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ps2_clk_i = 1'b1;
  logic       ps2_dat_i = 1'b1;
  logic       iorq_ni = 1'b1;
  logic       rd_ni = 1'b1;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_kc = 8'h00;
  bit done = 0;

  localparam int HALF_BIT = 20;
  localparam int TIMEOUT  = 10000;

  always #5 clk_i = ~clk_i;

  ps2_key_port i_ps2_key_port (.*);

  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // send a frame; start/parity/stop given explicitly
  task automatic send_bits(input logic [10:0] bits, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ps2_dat_i = bits[i];
      wait_n(HALF_BIT);
      ps2_clk_i = 1'b0;
      wait_n(HALF_BIT);
      ps2_clk_i = 1'b1;
    end
    ps2_dat_i = 1'b1;
    wait_n(10);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic p;
    p = odd_par(d) ^ bad_par;
    send_bits({~bad_stop, p, d, 1'b0}, 11);
  endtask

  task automatic port_read(input logic [7:0] hi, input string req);
    logic [7:0] first;
    @(negedge clk_i);
    addr_i = hi | 8'h08; iorq_ni = 1'b0; rd_ni = 1'b0;
    wait_n(1);
    first = data_o;
    chk(data_oe_o === 1'b1, "R2", int'(data_oe_o), 1);
    wait_n(2);
    chk(data_o === exp_kc, req, int'(data_o), int'(exp_kc));
    chk(data_o === first, "R6", int'(data_o), int'(first));
    iorq_ni = 1'b1; rd_ni = 1'b1;
    exp_kc = 8'h00;
    wait_n(3);
  endtask

  // cycle that must not select: address bit 3 low, or strobe missing
  task automatic dead_cycle(input int kind, input logic [7:0] a);
    @(negedge clk_i);
    case (kind)
      0: begin addr_i = a & 8'hF7; iorq_ni = 1'b0; rd_ni = 1'b0; end
      1: begin addr_i = a | 8'h08; iorq_ni = 1'b0; rd_ni = 1'b1; end
      default: begin addr_i = a | 8'h08; iorq_ni = 1'b1; rd_ni = 1'b0; end
    endcase
    wait_n(2);
    chk(data_oe_o === 1'b0, (kind == 0) ? "R2" : "R3", int'(data_oe_o), 0);
    iorq_ni = 1'b1; rd_ni = 1'b1;
    wait_n(3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    // R1
    chk(data_o === 8'h00, "R1", int'(data_o), 0);
    chk(data_oe_o === 1'b0, "R1", int'(data_oe_o), 0);
    port_read(8'h00, "R1");

    // R4 basic
    send_frame(8'hA5, 0, 0); exp_kc = 8'hA5;
    port_read(8'hF0, "R4");
    port_read(8'h00, "R5");

    // R7, R8 keep previous code
    send_frame(8'h3C, 0, 0); exp_kc = 8'h3C;
    send_frame(8'h81, 1, 0);
    port_read(8'h00, "R7");
    send_frame(8'h1F, 0, 0); exp_kc = 8'h1F;
    send_frame(8'h66, 0, 1);
    port_read(8'h00, "R8");

    // R9 all-ones burst never starts a frame
    send_bits(11'h7FF, 11);
    port_read(8'h00, "R9");
    send_frame(8'h02, 0, 0); exp_kc = 8'h02;
    port_read(8'h00, "R9");

    // R10 overwrite
    send_frame(8'h11, 0, 0);
    send_frame(8'h22, 0, 0); exp_kc = 8'h22;
    port_read(8'h00, "R10");

    // R3 write cycle and unselected access do not clear
    send_frame(8'h77, 0, 0); exp_kc = 8'h77;
    dead_cycle(1, 8'h08);
    dead_cycle(0, 8'hF7);
    port_read(8'h00, "R3");

    // R11 truncated frame then timeout
    send_bits(11'b000_0000_0110, 4);
    wait_n(TIMEOUT + 200);
    send_frame(8'h5A, 0, 0); exp_kc = 8'h5A;
    port_read(8'h00, "R11");

    // R12 code completes during a held read
    @(negedge clk_i);
    addr_i = 8'h08; iorq_ni = 1'b0; rd_ni = 1'b0;
    wait_n(2);
    chk(data_o === 8'h00, "R12", int'(data_o), 0);
    send_frame(8'hC3, 0, 0);
    chk(data_o === 8'h00, "R6", int'(data_o), 0);
    iorq_ni = 1'b1; rd_ni = 1'b1;
    wait_n(3);
    exp_kc = 8'hC3;
    port_read(8'h00, "R12");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic [7:0] d;
      kind = int'($urandom % 5);
      d = 8'($urandom);
      case (kind)
        0: begin send_frame(d, 0, 0); exp_kc = d; end
        1: send_frame(d, 1, 0);
        2: port_read(8'($urandom) & 8'hF7, "R4");
        3: dead_cycle(int'($urandom % 3), 8'($urandom));
        default: send_frame(d, 0, 1);
      endcase
    end
    port_read(8'h00, "R5");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule